// File: doc/BRIEF.md
# PCM Sample Streamer

This block sits in front of a console sound unit and turns its sample channel into a raw PCM player. Software sets a start address, a length and an enable bit by writing the sound unit's register window. The block catches the sample-address, sample-length and control writes. At a fixed interval of CPU cycles it fetches one byte from program memory through a request/acknowledge port. It halves the byte and presents it as a write to the sound unit's direct-output (DAC) register.

Every register write is still passed to the sound unit. A control write is passed with its enable bit cleared, so the native sample channel never starts. When the programmed length runs out, the block stops, raises an interrupt line and shows a done flag in bit 7 of the status read. Any later control write clears the flag and the interrupt.

Top module: `pcm_streamer`

## Requirements
- R1: A write to register offset 0x12 with data D sets the play address to D shifted left by 6. The play address is 15 bits, and the first fetch after the write presents that address on `mem_addr`.
- R2: A write to offset 0x13 with data D loads the remaining count with 16·D+1. One playback run from that count produces exactly 16·D+1 DAC writes before the done flag sets.
- R3: Every register write is passed to the sound unit in the same cycle with unchanged offset. The data is unchanged, except that for the control offset 0x15 bit 4 is forced to 0.
- R4: A control write (offset 0x15) makes the enable state equal to data bit 4 and clears the done flag and `irq` from the next cycle. With bit 4 at 0, no fetch is started afterwards.
- R5: After a control write that enables playback, the first fetch request appears on the clock edge that completes the PERIOD-th CPU tick (default 0xF6 = 246). Later fetches follow every PERIOD ticks.
- R6: The period countdown only advances in cycles where `cpu_tick` is 1. Cycles with `cpu_tick` at 0 do not move it.
- R7: At the first period expiry after the remaining count is used up, the done flag and `irq` go to 1 and playback stops. No further fetch is requested.
- R8: A DAC write (`dac_wr`) occurs exactly in the cycle a fetch is acknowledged, with `dac_wdata` equal to `mem_rdata` shifted right by one.
- R9: The play address advances by one per completed fetch and wraps from 0x7FFF to 0x0000. It holds still while a fetch waits for its acknowledge.
- R10: A status read returns `{done flag, snd_status[6:0]}`, with the flag in bit 7.
- R11: A period that expires while a fetch is still outstanding is not lost. The next fetch is requested right after the first one completes.
- R12: Reset clears the enable state, the done flag, `irq` and any pending fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_tick | input | 1 | One CPU cycle elapsed |
| reg_wr | input | 1 | CPU write to the sound register window |
| reg_off | input | 5 | Register offset within the window |
| reg_wdata | input | 8 | CPU write data |
| snd_wr | output | 1 | Forwarded write strobe to the sound unit |
| snd_off | output | 5 | Forwarded register offset |
| snd_wdata | output | 8 | Forwarded write data (control bit 4 cleared) |
| snd_status | input | 7 | Sound unit status bits 6:0 |
| status_rdata | output | 8 | Status read value with the done flag in bit 7 |
| irq | output | 1 | Playback-done interrupt (level) |
| mem_req | output | 1 | Sample fetch request, held until acknowledged |
| mem_addr | output | 15 | Sample fetch address |
| mem_ack | input | 1 | Fetch acknowledge, data valid in the same cycle |
| mem_rdata | input | 8 | Fetched sample byte |
| dac_wr | output | 1 | Write strobe to the sound unit's DAC register |
| dac_wdata | output | 8 | Halved sample value |

## Verification
On every cycle, the assertions check that the countdown stays inside one period while playing and that a waiting fetch keeps both its request and its address. They also check that the done flag can only rise together with playback stopping, that a control write clears the flag, and that a forwarded control write never carries the enable bit. Only the bench's scenarios can show the exact cycle of the first fetch, the count of DAC writes for a given length, and that idle CPU ticks stall the countdown. The same holds for two expiries collapsing into back-to-back fetches, and for the address wrap after more than sixteen thousand fetches.

// File: rtl/pcm_stream_pkg.sv
package pcm_stream_pkg;

    localparam int ADDR_W   = 15;
    localparam int BYTE_W   = 8;
    localparam int OFF_W    = 5;
    localparam int LEN_W    = 14;
    localparam int ADDR_SHL = 6;
    localparam int LEN_SHL  = 4;
    localparam int EN_BIT   = 4;

    localparam logic [OFF_W-1:0] OFF_START = 5'h12;
    localparam logic [OFF_W-1:0] OFF_COUNT = 5'h13;
    localparam logic [OFF_W-1:0] OFF_CTRL  = 5'h15;

    typedef enum logic {PLAY_OFF, PLAY_ON} play_t;

    typedef struct packed {
        logic              ld_start;
        logic              ld_count;
        logic              ld_ctrl;
        logic [BYTE_W-1:0] data;
    } cfg_wr_t;

    function automatic logic [ADDR_W-1:0] start_from_reg(input logic [BYTE_W-1:0] d);
        return ADDR_W'({d, {ADDR_SHL{1'b0}}});
    endfunction

    function automatic logic signed [LEN_W-1:0] count_from_reg(input logic [BYTE_W-1:0] d);
        return LEN_W'({d, {LEN_SHL{1'b0}}}) + LEN_W'(1);
    endfunction

    function automatic logic [BYTE_W-1:0] halve_sample(input logic [BYTE_W-1:0] d);
        return d >> 1;
    endfunction

endpackage

// File: rtl/pcm_reg_decode.sv
module pcm_reg_decode
    import pcm_stream_pkg::*;
(
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [BYTE_W-1:0] reg_wdata,
    output cfg_wr_t           cfg,
    output logic              fwd_wr,
    output logic [OFF_W-1:0]  fwd_off,
    output logic [BYTE_W-1:0] fwd_wdata
);
    always_comb begin
        cfg.ld_start = reg_wr && (reg_off == OFF_START);
        cfg.ld_count = reg_wr && (reg_off == OFF_COUNT);
        cfg.ld_ctrl  = reg_wr && (reg_off == OFF_CTRL);
        cfg.data     = reg_wdata;

        fwd_wr    = reg_wr;
        fwd_off   = reg_off;
        fwd_wdata = reg_wdata;
        if (reg_off == OFF_CTRL) begin
            fwd_wdata[EN_BIT] = 1'b0;
        end
    end
endmodule

// File: rtl/pcm_pacer.sv
module pcm_pacer
    import pcm_stream_pkg::*;
#(
    parameter int PERIOD = 246
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  cfg_wr_t cfg,
    output logic    fire,
    output logic    done_flag
);
    localparam int CNT_W = $clog2(PERIOD + 1) + 1;
    localparam logic signed [CNT_W-1:0] PERIOD_C = CNT_W'(PERIOD);
    localparam logic signed [CNT_W-1:0] ONE_C    = CNT_W'(1);
    localparam logic signed [LEN_W-1:0] ONE_L    = LEN_W'(1);

    play_t                   state;
    logic signed [CNT_W-1:0] cnt;
    logic signed [CNT_W-1:0] cnt_dec;
    logic signed [LEN_W-1:0] remain;
    logic signed [LEN_W-1:0] remain_dec;
    logic                    expire;
    logic                    finish;

    always_comb begin
        cnt_dec    = cnt - ONE_C;
        remain_dec = remain - ONE_L;
        expire     = (state == PLAY_ON) && tick && !cfg.ld_ctrl &&
                     (cnt_dec[CNT_W-1] || (cnt_dec == '0));
        finish     = expire && remain_dec[LEN_W-1];
        fire       = expire && !remain_dec[LEN_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PLAY_OFF;
            cnt       <= '0;
            remain    <= '0;
            done_flag <= 1'b0;
        end else begin
            if (cfg.ld_count) begin
                remain <= count_from_reg(cfg.data);
            end else if (expire) begin
                remain <= remain_dec;
            end

            if (cfg.ld_ctrl) begin
                done_flag <= 1'b0;
                if (cfg.data[EN_BIT]) begin
                    state <= PLAY_ON;
                    cnt   <= PERIOD_C;
                end else begin
                    state <= PLAY_OFF;
                end
            end else if ((state == PLAY_ON) && tick) begin
                if (expire) begin
                    cnt <= cnt_dec + PERIOD_C;
                end else begin
                    cnt <= cnt_dec;
                end
                if (finish) begin
                    done_flag <= 1'b1;
                    state     <= PLAY_OFF;
                end
            end
        end
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state == PLAY_ON) |-> ((cnt > '0) && (cnt <= PERIOD_C)));

    // R7
    stop_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> (state == PLAY_OFF));

    // R4
    ctrl_clears_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.ld_ctrl |=> !done_flag);

    // R12
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done_flag && (state == PLAY_OFF)));
endmodule

// File: rtl/pcm_fetch.sv
module pcm_fetch
    import pcm_stream_pkg::*;
#(
    parameter int BACKLOG_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_wr_t           cfg,
    input  logic              fire,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              dac_wr,
    output logic [BYTE_W-1:0] dac_wdata
);
    localparam logic [BACKLOG_W-1:0] BL_MAX = '1;
    localparam logic [BACKLOG_W-1:0] BL_ONE = BACKLOG_W'(1);

    logic [BACKLOG_W-1:0] backlog;
    logic                 take;

    always_comb begin
        mem_req   = (backlog != '0);
        take      = mem_req && mem_ack;
        dac_wr    = take;
        dac_wdata = halve_sample(mem_rdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            backlog  <= '0;
            mem_addr <= '0;
        end else begin
            unique case ({fire, take})
                2'b10:   if (backlog != BL_MAX) backlog <= backlog + BL_ONE;
                2'b01:   backlog <= backlog - BL_ONE;
                default: backlog <= backlog;
            endcase

            if (cfg.ld_start) begin
                mem_addr <= start_from_reg(cfg.data);
            end else if (take) begin
                mem_addr <= mem_addr + ADDR_W'(1);
            end
        end
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req);

    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !cfg.ld_start) |=> $stable(mem_addr));
endmodule

// File: rtl/pcm_streamer.sv
module pcm_streamer
    import pcm_stream_pkg::*;
#(
    parameter int PERIOD    = 246,
    parameter int BACKLOG_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_tick,
    input  logic              reg_wr,
    input  logic [OFF_W-1:0]  reg_off,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic              snd_wr,
    output logic [OFF_W-1:0]  snd_off,
    output logic [BYTE_W-1:0] snd_wdata,
    input  logic [6:0]        snd_status,
    output logic [BYTE_W-1:0] status_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              dac_wr,
    output logic [BYTE_W-1:0] dac_wdata
);
    cfg_wr_t cfg;
    logic    fire;
    logic    done_flag;

    pcm_reg_decode u_decode (
        .reg_wr    (reg_wr),
        .reg_off   (reg_off),
        .reg_wdata (reg_wdata),
        .cfg       (cfg),
        .fwd_wr    (snd_wr),
        .fwd_off   (snd_off),
        .fwd_wdata (snd_wdata)
    );

    pcm_pacer #(.PERIOD(PERIOD)) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .tick      (cpu_tick),
        .cfg       (cfg),
        .fire      (fire),
        .done_flag (done_flag)
    );

    pcm_fetch #(.BACKLOG_W(BACKLOG_W)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .fire      (fire),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .dac_wr    (dac_wr),
        .dac_wdata (dac_wdata)
    );

    always_comb begin
        status_rdata = {done_flag, snd_status};
        irq          = done_flag;
    end

    // R3
    fwd_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (snd_wr && (snd_off == OFF_CTRL)) |-> !snd_wdata[EN_BIT]);
endmodule

// File: tb/pcm_streamer_bench.sv
module pcm_streamer_bench;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic        cpu_tick = 1'b1;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_off = '0;
    logic [7:0]  reg_wdata = '0;
    logic        snd_wr;
    logic [4:0]  snd_off;
    logic [7:0]  snd_wdata;
    logic [6:0]  snd_status = '0;
    logic [7:0]  status_rdata;
    logic        irq, mem_req, mem_ack, dac_wr;
    logic [14:0] mem_addr;
    logic [7:0]  mem_rdata, dac_wdata;
    logic        ack_hold = 1'b0;

    assign mem_ack   = mem_req && !ack_hold;
    assign mem_rdata = mem_addr[7:0] ^ 8'hA5;

    pcm_streamer u_pcm_streamer (
        .clk(clk), .rst(rst), .cpu_tick(cpu_tick),
        .reg_wr(reg_wr), .reg_off(reg_off), .reg_wdata(reg_wdata),
        .snd_wr(snd_wr), .snd_off(snd_off), .snd_wdata(snd_wdata),
        .snd_status(snd_status), .status_rdata(status_rdata), .irq(irq),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .dac_wr(dac_wr), .dac_wdata(dac_wdata)
    );

    // short-period copy used for the address wrap
    logic        f_wr = 1'b0;
    logic [4:0]  f_off = '0;
    logic [7:0]  f_wdata = '0;
    logic        f_snd_wr, f_irq, f_req, f_dac_wr;
    logic [4:0]  f_snd_off;
    logic [7:0]  f_snd_wdata, f_status, f_dac_wdata;
    logic [14:0] f_addr;

    pcm_streamer #(.PERIOD(2)) u_pcm_streamer_fast (
        .clk(clk), .rst(rst), .cpu_tick(1'b1),
        .reg_wr(f_wr), .reg_off(f_off), .reg_wdata(f_wdata),
        .snd_wr(f_snd_wr), .snd_off(f_snd_off), .snd_wdata(f_snd_wdata),
        .snd_status(7'h00), .status_rdata(f_status), .irq(f_irq),
        .mem_req(f_req), .mem_addr(f_addr), .mem_ack(f_req),
        .mem_rdata(8'h00), .dac_wr(f_dac_wr), .dac_wdata(f_dac_wdata)
    );

    int compared = 0;
    int mismatched = 0;
    int dac_cnt = 0;
    int f_cnt = 0;
    logic [14:0] exp_addr = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] o, input logic [7:0] d);
        reg_wr = 1'b1; reg_off = o; reg_wdata = d;
        if (o == 5'h12) exp_addr = 15'({d, 6'b0});
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic fwr(input logic [4:0] o, input logic [7:0] d);
        f_wr = 1'b1; f_off = o; f_wdata = d;
        @(negedge clk);
        f_wr = 1'b0;
    endtask

    // R8 and R9: every DAC write carries the halved byte of the expected address
    always @(negedge clk) begin
        if (dac_wr) begin
            chk(mem_addr == exp_addr, "R9 fetch address", mem_addr, exp_addr);
            chk(dac_wdata == ((mem_addr[7:0] ^ 8'hA5) >> 1), "R8 dac value",
                dac_wdata, (mem_addr[7:0] ^ 8'hA5) >> 1);
            exp_addr = exp_addr + 15'd1;
            dac_cnt++;
        end
        if (f_dac_wr) begin
            if (f_cnt == 16447) chk(f_addr == 15'h7FFF, "R9 wrap top", f_addr, 15'h7FFF);
            if (f_cnt == 16448) chk(f_addr == 15'h0000, "R9 wrap zero", f_addr, 0);
            f_cnt++;
        end
    end

    // offset, data, status in, forwarded data, status read
    localparam logic [35:0] VECS [0:5] = '{
        {5'h00, 8'h5A, 7'h7F, 8'h5A, 8'h7F},
        {5'h11, 8'hFF, 7'h00, 8'hFF, 8'h00},
        {5'h15, 8'hFF, 7'h3C, 8'hEF, 8'h3C},
        {5'h15, 8'h10, 7'h41, 8'h00, 8'h41},
        {5'h12, 8'h37, 7'h00, 8'h37, 8'h00},
        {5'h15, 8'h2F, 7'h55, 8'h2F, 8'h55}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!irq && !mem_req && !dac_wr, "R12 idle after reset", {irq, mem_req, dac_wr}, 0);
        snd_status = 7'h7F; #1;
        chk(status_rdata == 8'h7F, "R12 status bit7 clear", status_rdata, 8'h7F);

        // R3 / R10 vector walk
        for (int i = 0; i < 6; i++) begin
            reg_wr = 1'b1; reg_off = VECS[i][35:31]; reg_wdata = VECS[i][30:23];
            snd_status = VECS[i][22:16];
            #1;
            chk(snd_wr && snd_off == VECS[i][35:31], "R3 forwarded offset", snd_off, VECS[i][35:31]);
            chk(snd_wdata == VECS[i][15:8], "R3 forwarded data", snd_wdata, VECS[i][15:8]);
            chk(status_rdata == VECS[i][7:0], "R10 status overlay", status_rdata, VECS[i][7:0]);
            @(negedge clk);
            reg_wr = 1'b0;
        end

        // R5 R1 R2 R7: length 0 gives one sample, first at tick 246
        wr(5'h12, 8'h02);
        wr(5'h13, 8'h00);
        dac_cnt = 0;
        wr(5'h15, 8'h10);
        repeat (245) @(negedge clk);
        chk(!mem_req, "R5 no fetch before period", mem_req, 0);
        @(negedge clk);
        chk(mem_req, "R5 fetch at period", mem_req, 1);
        chk(mem_addr == 15'h0080, "R1 start address", mem_addr, 15'h0080);
        repeat (245) @(negedge clk);
        chk(!irq, "R7 irq not yet", irq, 0);
        @(negedge clk);
        chk(irq, "R7 irq at exhaustion", irq, 1);
        snd_status = 7'h12; #1;
        chk(status_rdata == 8'h92, "R10 flag in bit7", status_rdata, 8'h92);
        chk(dac_cnt == 1, "R2 one sample for length 0", dac_cnt, 1);
        repeat (600) @(negedge clk);
        chk(!mem_req && dac_cnt == 1, "R7 stopped after done", dac_cnt, 1);

        // R4 control write clears flag and disables
        wr(5'h15, 8'h00);
        chk(!irq && !status_rdata[7], "R4 flag cleared", irq, 0);
        repeat (600) @(negedge clk);
        chk(!mem_req && dac_cnt == 1, "R4 disabled no fetch", dac_cnt, 1);

        // R2 R9 length 1 gives 17 samples
        wr(5'h12, 8'h01);
        wr(5'h13, 8'h01);
        dac_cnt = 0;
        wr(5'h15, 8'h10);
        for (int k = 0; k < 6000 && !irq; k++) @(negedge clk);
        chk(dac_cnt == 17, "R2 seventeen samples", dac_cnt, 17);
        chk(exp_addr == 15'h0051, "R9 address advanced", exp_addr, 15'h0051);

        // R6 idle ticks stall the countdown
        wr(5'h15, 8'h00);
        wr(5'h13, 8'h00);
        cpu_tick = 1'b0;
        wr(5'h15, 8'h10);
        repeat (1000) @(negedge clk);
        chk(!mem_req, "R6 no progress without ticks", mem_req, 0);
        cpu_tick = 1'b1;
        repeat (245) @(negedge clk);
        chk(!mem_req, "R6 one tick short", mem_req, 0);
        @(negedge clk);
        chk(mem_req, "R6 fetch after 246 ticks", mem_req, 1);
        wr(5'h15, 8'h00);

        // R11 two expiries while the first fetch waits
        wr(5'h13, 8'h01);
        wr(5'h12, 8'h04);
        ack_hold = 1'b1;
        dac_cnt = 0;
        wr(5'h15, 8'h10);
        repeat (500) @(negedge clk);
        chk(mem_req && dac_cnt == 0, "R11 fetch waiting", dac_cnt, 0);
        @(posedge clk); #1;
        ack_hold = 1'b0;
        repeat (3) @(negedge clk);
        chk(dac_cnt == 2, "R11 both fetches served", dac_cnt, 2);
        chk(!mem_req, "R11 backlog drained", mem_req, 0);
        wr(5'h15, 8'h00);

        // R12 reset during a run
        wr(5'h13, 8'h00);
        wr(5'h15, 8'h10);
        repeat (600) @(negedge clk);
        chk(irq, "R7 done before reset", irq, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!irq && !status_rdata[7] && !mem_req, "R12 reset clears", irq, 0);

        // R9 wrap on the short-period copy
        fwr(5'h12, 8'hFF);
        for (int run = 0; run < 6 && f_cnt <= 16449; run++) begin
            fwr(5'h13, 8'hFF);
            fwr(5'h15, 8'h10);
            for (int k = 0; k < 12000 && !f_irq; k++) @(negedge clk);
            fwr(5'h15, 8'h00);
        end
        chk(f_cnt > 16449, "R9 wrap reached", f_cnt, 16450);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule